// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

A watchdog timer that sits on a simple register bus and counts upward on ticks of a slow functional clock, about 32 kHz. The `tick` input is a one-cycle enable that marks each functional-clock edge. When the counter is armed and wraps past all ones, the block raises `rst_req` for one cycle and restarts from the load value. Software keeps the system alive by writing the trigger register with a value that differs from the last one it wrote. Each such write copies the load value into the counter.

Arming and disarming are guarded by two-word key sequences written to the key register. Each write-side register has a pending flag that models a posted write crossing into the counter domain. The flag stays busy for a fixed number of ticks, and the block drops any write to that register while its flag is set. An optional prescaler slows the count by a power of two.

Word addresses on `bus_addr`: 0 revision, 1 system config, 2 pending status, 3 control, 4 counter, 5 load, 6 trigger, 7 key.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the timer is armed, and the counter, load, control, system-config and pending registers all read 0.
- R2: While armed with the prescaler off, the counter rises by one on each cycle with `tick` high. Without a tick or a reload it holds its value.
- R3: Control bit 5 enables the prescaler, and control bits 4:2 hold an exponent k. With the prescaler on, the counter advances once every 2^k ticks.
- R4: A write to the trigger register copies the load register into the counter. This happens only if the value written differs from the last trigger value, which is 0 after reset.
- R5: When the armed counter wraps past 0xFFFFFFFF, `rst_req` is high for exactly one cycle and the counter takes the load value.
- R6: Writing 0xAAAA and then 0x5555 to the key register disarms the timer. A disarmed counter freezes and never raises `rst_req`.
- R7: Writing 0xBBBB and then 0x4444 to the key register arms the timer.
- R8: A second key word that does not come directly after its first word, or any other key value, cancels the sequence and leaves the armed state unchanged.
- R9: The pending status register flags control at bit 0, load at bit 2, trigger at bit 3 and key at bit 4. A flag sets on an accepted write and clears after PEND_TICKS ticks.
- R10: A write to a register whose pending flag is set is ignored.
- R11: The revision register reads REV_CODE in bits 7:0 and zero above. The system-config register stores bit 0 only.
- R12: A write to the load register does not change the counter. The new value takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable per functional-clock edge |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_req | output | 1 | One-cycle reset request on armed overflow |

## Verification
The bench repeats a trigger value to confirm that a stale kick does not reload the counter; a design that reloaded on every trigger write would fail this. It interleaves key words, sending BBBB between AAAA and 5555 and sending a stray value between BBBB and 4444. A design that only remembered "first word seen" would then wrongly change the armed state. Wraps are driven from a load value just below all ones to check that each overflow gives exactly one request pulse and a reload from the load value, including a load value that changes just before the wrap. The prescaler is stopped one tick short of its period to catch an off-by-one divider. A second write while a flag is busy must be dropped.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int          PEND_TICKS = 4,
  parameter logic [7:0]  REV_CODE   = 8'h31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        rst_req
);
  localparam int PW = $clog2(PEND_TICKS + 1);
  localparam logic [2:0] A_REV = 3'd0, A_SYSC = 3'd1, A_PEND = 3'd2, A_CTRL = 3'd3,
                         A_CNT = 3'd4, A_LOAD = 3'd5, A_TRIG = 3'd6, A_KEY  = 3'd7;

  typedef enum logic [1:0] {K_IDLE, K_DIS, K_ARM} key_t;

  logic [31:0] cnt, load_q, last_trig;
  logic [3:0]  ctrl_q;
  logic        sysc_q, armed;
  logic [7:0]  pre_cnt;
  key_t        stage;
  logic [PW-1:0] pc [4];
  logic [3:0]  busy;
  logic [4:0]  pend;

  assign pend = {busy[3], busy[2], busy[1], 1'b0, busy[0]};

  wire wr      = bus_sel & bus_we;
  wire wr_ctrl = wr && bus_addr == A_CTRL && !pend[0];
  wire wr_load = wr && bus_addr == A_LOAD && !pend[2];
  wire wr_trig = wr && bus_addr == A_TRIG && !pend[3];
  wire wr_key  = wr && bus_addr == A_KEY  && !pend[4];
  wire [3:0] hit = {wr_key, wr_trig, wr_load, wr_ctrl};

  wire [2:0] ptv    = ctrl_q[2:0];
  wire       pre_on = ctrl_q[3];
  wire       step   = tick && (!pre_on || pre_cnt == ((8'd1 << ptv) - 8'd1));
  wire       ovf    = armed && step && (cnt == 32'hFFFF_FFFF);
  wire       reload = wr_trig && (bus_wdata != last_trig);

  genvar i;
  generate
    for (i = 0; i < 4; i++) begin : g_pend
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pc[i] <= '0;
        else if (hit[i])             pc[i] <= PW'(PEND_TICKS);
        else if (tick && pc[i] != 0) pc[i] <= pc[i] - 1'b1;
      end
      assign busy[i] = (pc[i] != 0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      load_q    <= '0;
      last_trig <= '0;
      ctrl_q    <= '0;
      sysc_q    <= 1'b0;
      armed     <= 1'b1;
      pre_cnt   <= '0;
      stage     <= K_IDLE;
      rst_req   <= 1'b0;
    end else begin
      rst_req <= ovf;
      if (tick) pre_cnt <= step ? 8'd0 : pre_cnt + 8'd1;

      if (reload || ovf)       cnt <= load_q;
      else if (armed && step)  cnt <= cnt + 32'd1;

      if (wr_ctrl) ctrl_q <= bus_wdata[5:2];
      if (wr && bus_addr == A_SYSC) sysc_q <= bus_wdata[0];
      if (wr_load) load_q <= bus_wdata;
      if (wr_trig) last_trig <= bus_wdata;

      if (wr_key) begin
        if (bus_wdata == 32'h0000_AAAA)      stage <= K_DIS;
        else if (bus_wdata == 32'h0000_BBBB) stage <= K_ARM;
        else begin
          stage <= K_IDLE;
          if (bus_wdata == 32'h0000_5555 && stage == K_DIS) armed <= 1'b0;
          if (bus_wdata == 32'h0000_4444 && stage == K_ARM) armed <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_REV:   bus_rdata = {24'd0, REV_CODE};
      A_SYSC:  bus_rdata = {31'd0, sysc_q};
      A_PEND:  bus_rdata = {27'd0, pend};
      A_CTRL:  bus_rdata = {26'd0, ctrl_q, 2'b00};
      A_CNT:   bus_rdata = cnt;
      A_LOAD:  bus_rdata = load_q;
      A_TRIG:  bus_rdata = last_trig;
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        rst_req,
  input logic        armed,
  input logic [31:0] cnt,
  input logic [31:0] load_q,
  input logic [4:0]  pend
);
  wire trig_wr = bus_sel && bus_we && bus_addr == 3'd6;
  wire load_wr = bus_sel && bus_we && bus_addr == 3'd5;
  wire key_wr  = bus_sel && bus_we && bus_addr == 3'd7;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !trig_wr) |=> $stable(cnt));

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && $stable(load_q)) |-> cnt == load_q);

  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !trig_wr) |=> $stable(cnt));

  a_r6_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !rst_req);

  a_r10_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (load_wr && pend[2]) |=> $stable(load_q));

  a_r8_other_key: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && bus_wdata != 32'h5555 && bus_wdata != 32'h4444) |=> $stable(armed));

  a_r9_gap_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[1]);
endmodule

bind keyed_wdt keyed_wdt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rst_req(rst_req), .armed(armed),
  .cnt(cnt), .load_q(load_q), .pend(pend)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;

  typedef struct {
    bit          is_pulse;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  keyed_wdt #(.PEND_TICKS(4), .REV_CODE(8'h31)) u_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (rst_req === 1'b1) pulses++;

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.is_pulse ? 32'(pulses) : bus_rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.is_pulse = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    #4;
  endtask

  task automatic exp_pulses(input int e, input string tag);
    item_t it;
    it.is_pulse = 1'b1; it.exp = 32'(e); it.tag = tag;
    q.push_back(it);
    #4;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    exp_rd(3'd0, 32'h31, "R11 revision");
    exp_rd(3'd4, 32'h0, "R1 counter");
    exp_rd(3'd5, 32'h0, "R1 load");
    exp_rd(3'd3, 32'h0, "R1 control");
    exp_rd(3'd2, 32'h0, "R1 pending");
    exp_rd(3'd1, 32'h0, "R1 sysconfig");

    ticks(5);
    exp_rd(3'd4, 32'd5, "R2 count per tick");
    repeat (3) @(negedge clk);
    exp_rd(3'd4, 32'd5, "R2 hold without tick");

    wr(3'd5, 32'h100);
    exp_rd(3'd4, 32'd5, "R12 load leaves counter");
    exp_rd(3'd2, 32'h04, "R9 load flag bit2");
    wr(3'd5, 32'h200);
    exp_rd(3'd5, 32'h100, "R10 busy load ignored");
    ticks(4);
    exp_rd(3'd2, 32'h0, "R9 flag clears");
    exp_rd(3'd4, 32'd9, "R2 count");

    wr(3'd6, 32'h1);
    exp_rd(3'd4, 32'h100, "R4 trigger reload");
    exp_rd(3'd2, 32'h08, "R9 trigger flag bit3");
    ticks(4);
    wr(3'd6, 32'h1);
    exp_rd(3'd4, 32'h104, "R4 same trigger ignored");
    ticks(4);
    wr(3'd6, 32'h2);
    exp_rd(3'd4, 32'h100, "R4 new trigger reload");
    ticks(4);

    wr(3'd3, 32'h28);
    exp_rd(3'd3, 32'h28, "R3 control readback");
    ticks(4);
    exp_rd(3'd4, 32'h105, "R3 divide by 4");
    wr(3'd6, 32'h3);
    ticks(4);
    ticks(8);
    exp_rd(3'd4, 32'h103, "R3 prescaled count");
    ticks(3);
    exp_rd(3'd4, 32'h103, "R3 one tick short");
    ticks(1);
    exp_rd(3'd4, 32'h104, "R3 period reached");
    wr(3'd3, 32'h0);
    ticks(4);
    exp_rd(3'd4, 32'h108, "R3 prescaler off");

    wr(3'd5, 32'hFFFF_FFFC);
    ticks(4);
    wr(3'd6, 32'h4);
    exp_pulses(0, "R5 no pulse before wrap");
    ticks(4);
    exp_pulses(1, "R5 pulse on wrap");
    exp_rd(3'd4, 32'hFFFF_FFFC, "R5 reload on wrap");
    repeat (2) @(negedge clk);
    exp_pulses(1, "R5 single cycle");
    ticks(5);
    exp_pulses(2, "R5 second wrap");
    exp_rd(3'd4, 32'hFFFF_FFFD, "R5 count after wrap");

    wr(3'd5, 32'h10);
    ticks(4);
    exp_rd(3'd4, 32'h11, "R12 new load used at reload");
    exp_pulses(3, "R5 third wrap");

    wr(3'd7, 32'hAAAA);
    ticks(4);
    wr(3'd7, 32'h5555);
    ticks(4);
    exp_rd(3'd4, 32'h15, "R6 disarmed freezes");
    ticks(4);
    exp_rd(3'd4, 32'h15, "R6 still frozen");
    exp_pulses(3, "R6 no request");

    wr(3'd7, 32'hBBBB);
    ticks(4);
    wr(3'd7, 32'h1234);
    ticks(4);
    wr(3'd7, 32'h4444);
    ticks(4);
    exp_rd(3'd4, 32'h15, "R8 broken arm sequence");

    wr(3'd7, 32'hBBBB);
    ticks(4);
    wr(3'd7, 32'h4444);
    ticks(4);
    exp_rd(3'd4, 32'h19, "R7 armed counts");

    wr(3'd7, 32'hAAAA);
    ticks(4);
    wr(3'd7, 32'hBBBB);
    ticks(4);
    wr(3'd7, 32'h5555);
    ticks(4);
    exp_rd(3'd4, 32'h25, "R8 interleaved disarm");

    wr(3'd1, 32'hFFFF_FFFF);
    exp_rd(3'd1, 32'h1, "R11 sysconfig bit0");

    wr(3'd3, 32'h0);
    wr(3'd5, 32'h10);
    wr(3'd6, 32'h6);
    wr(3'd7, 32'h0);
    exp_rd(3'd2, 32'h1D, "R9 all flag positions");
    exp_rd(3'd4, 32'h10, "R4 reload");
    ticks(3);
    exp_rd(3'd2, 32'h1D, "R9 flags before PEND_TICKS");
    ticks(1);
    exp_rd(3'd2, 32'h0, "R9 flags after PEND_TICKS");
    exp_rd(3'd4, 32'h14, "R2 count");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule